// File: doc/BRIEF.md
# Host Port Access Sequencer

This block lets a local processor reach a DSP's host port one word at a time. The processor hands over one request on a valid/ready handshake: an address, write data and a direction. The sequencer then runs a fixed sequence on the host port. First it sets up the address and direction. Then it pulls the strobe low for a programmable minimum time with at least one wait state. It stays in the low phase until the slave's active-low ready line shows the port is no longer busy. It then releases the strobe and holds it high for a programmable recovery time before it accepts the next request.

The busy line comes from the slave's clock domain, so it passes through a synchroniser before the state machine reads it. Read data is sampled only after the synchronised busy line has dropped. The word is returned on `rdata_o` together with a done pulse that lasts one cycle. An access whose ready never arrives is abandoned after a programmable number of cycles, and an error pulse is raised instead of done. A transfer of several words is issued as one request per word. Each word gets its full strobe-low and recovery intervals, so the words stay in order.

Top module: `host_port_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle with the strobe high. A request is taken on a cycle where both `req_valid_i` and `req_ready_o` are high. After reset the strobe is high, and `done_o` and `err_o` are low.
- R2: Each completed access holds `hp_strobe_no` low for exactly max(L, W+2, B+3) cycles. L is `cfg_low_i` with 0 read as 1. W is the effective wait count. B is the number of low cycles during which `hp_busy_i` stays high.
- R3: A `cfg_wait_i` of 0 is treated as 1. With L=1 and no busy, the strobe is low for exactly 3 cycles, and never for fewer than 2.
- R4: Between two accesses the strobe stays high for at least H cycles, where H is `cfg_high_i` with 0 read as 1.
- R5: `hp_busy_i` (high = busy) passes through a two-stage synchroniser. An access completes, and read data is sampled, only once the synchronised busy is low. Data the slave presents while busy is never returned.
- R6: `done_o` is a pulse of exactly one cycle per completed access. On a read, `rdata_o` carries the word that was read while done is high, and keeps it afterwards.
- R7: On a write, `hp_rnw_o` is 0 and `hp_data_oe_o` is high with `hp_data_o` driven for the whole strobe-low phase. On a read, `hp_rnw_o` is 1.
- R8: `hp_addr_o`, `hp_rnw_o` and `hp_data_o` hold steady through the strobe-low phase.
- R9: If the access has not completed when the low-phase counter reaches `cfg_timeout_i`, the strobe is released. In that case the strobe was low for `cfg_timeout_i`+1 cycles. `err_o` then pulses for one cycle, no done is given, and the normal recovery interval follows.
- R10: Back-to-back single-word requests to consecutive addresses return their words in request order, each with its own full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| cfg_low_i | input | CNT_W | Minimum strobe-low cycles (0 read as 1) |
| cfg_high_i | input | CNT_W | Minimum strobe-high recovery cycles (0 read as 1) |
| cfg_wait_i | input | CNT_W | Wait states before ready is sampled (0 read as 1) |
| cfg_timeout_i | input | TO_W | Low-phase cycle limit before abort |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| rdata_o | output | DW | Last word read |
| hp_strobe_no | output | 1 | Host port strobe, active low |
| hp_rnw_o | output | 1 | 1 = read, 0 = write |
| hp_addr_o | output | AW | Host port address |
| hp_data_o | output | DW | Host port write data |
| hp_data_oe_o | output | 1 | Write data drive enable |
| hp_data_i | input | DW | Host port read data |
| hp_busy_i | input | 1 | Slave busy (its ready line, high while busy) |

## Verification
The bench builds the block with AW=8, DW=16, CNT_W=6 and TO_W=8. A timeout of a few dozen cycles is therefore reachable in a short run, and random interval settings span the full range where the strobe-low length is set by the low minimum, by the wait count or by the busy time. The slave model returns inverted data while it is busy, so any sample taken before the synchronised busy drops shows up as a wrong word. The exact strobe-low length is checked on every access.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
  typedef enum logic [2:0] {
    HP_IDLE,
    HP_SETUP,
    HP_LOW,
    HP_CAPT,
    HP_RECOV
  } hp_state_e;
endpackage

// File: rtl/host_port_sync.sv
module host_port_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/host_port_gate.sv
module host_port_gate #(
  parameter int CNT_W       = 8,
  parameter int TO_W        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic [TO_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0] cfg_low_i,
  input  logic [CNT_W-1:0] cfg_high_i,
  input  logic [CNT_W-1:0] cfg_wait_i,
  input  logic [TO_W-1:0]  cfg_timeout_i,
  output logic             low_done_o,
  output logic             high_done_o,
  output logic             timeout_o
);
  localparam int EW = TO_W + 2;

  logic [EW-1:0] cnt_x, low_eff, high_eff, wait_eff;

  assign cnt_x    = EW'(cnt_i);
  assign low_eff  = (cfg_low_i  == '0) ? EW'(1) : EW'(cfg_low_i);
  assign high_eff = (cfg_high_i == '0) ? EW'(1) : EW'(cfg_high_i);
  assign wait_eff = (cfg_wait_i == '0) ? EW'(1) : EW'(cfg_wait_i);

  // ready may be trusted only once wait states plus sync latency have passed
  assign low_done_o  = (cnt_x >= wait_eff + EW'(SYNC_STAGES - 1)) &&
                       (cnt_x + EW'(1) >= low_eff);
  // capture cycle counts as the first high cycle
  assign high_done_o = (cnt_x + EW'(2) >= high_eff);
  assign timeout_o   = (cnt_i >= cfg_timeout_i);
endmodule

// File: rtl/host_port_seq.sv
module host_port_seq
  import host_port_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CNT_W       = 8,
  parameter int TO_W        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [CNT_W-1:0] cfg_low_i,
  input  logic [CNT_W-1:0] cfg_high_i,
  input  logic [CNT_W-1:0] cfg_wait_i,
  input  logic [TO_W-1:0]  cfg_timeout_i,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o,
  output logic             hp_strobe_no,
  output logic             hp_rnw_o,
  output logic [AW-1:0]    hp_addr_o,
  output logic [DW-1:0]    hp_data_o,
  output logic             hp_data_oe_o,
  input  logic [DW-1:0]    hp_data_i,
  input  logic             hp_busy_i
);
  hp_state_e       state_q;
  logic [TO_W-1:0] cnt_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            write_q, err_q;
  logic            busy_s, low_done, high_done, timeout;

  host_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hp_busy_i),
    .q_o   (busy_s)
  );

  host_port_gate #(.CNT_W(CNT_W), .TO_W(TO_W), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .cnt_i        (cnt_q),
    .cfg_low_i    (cfg_low_i),
    .cfg_high_i   (cfg_high_i),
    .cfg_wait_i   (cfg_wait_i),
    .cfg_timeout_i(cfg_timeout_i),
    .low_done_o   (low_done),
    .high_done_o  (high_done),
    .timeout_o    (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HP_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        HP_IDLE: begin
          cnt_q <= '0;
          if (req_valid_i) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            write_q <= req_write_i;
            state_q <= HP_SETUP;
          end
        end
        HP_SETUP: begin
          cnt_q   <= '0;
          state_q <= HP_LOW;
        end
        HP_LOW: begin
          if (low_done && !busy_s) begin
            if (!write_q) rdata_q <= hp_data_i;
            state_q <= HP_CAPT;
          end else if (timeout) begin
            err_q   <= 1'b1;
            cnt_q   <= '0;
            state_q <= HP_RECOV;
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HP_CAPT: begin
          cnt_q   <= '0;
          state_q <= HP_RECOV;
        end
        HP_RECOV: begin
          if (high_done)        state_q <= HP_IDLE;
          else if (cnt_q != '1) cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= HP_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == HP_IDLE);
  assign done_o       = (state_q == HP_CAPT);
  assign err_o        = err_q;
  assign rdata_o      = rdata_q;
  assign hp_strobe_no = (state_q != HP_LOW);
  assign hp_rnw_o     = !write_q;
  assign hp_addr_o    = addr_q;
  assign hp_data_o    = wdata_q;
  assign hp_data_oe_o = write_q && (state_q == HP_SETUP || state_q == HP_LOW);
endmodule

// File: rtl/host_port_seq_chk.sv
module host_port_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          done_o,
  input logic          err_o,
  input logic          hp_strobe_no,
  input logic          hp_rnw_o,
  input logic [AW-1:0] hp_addr_o,
  input logic [DW-1:0] hp_data_o,
  input logic          hp_data_oe_o
);
  // R1
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> hp_strobe_no);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R3
  min_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hp_strobe_no) |=> !hp_strobe_no);

  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hp_strobe_no && $past(!hp_strobe_no)) |->
      ($stable(hp_addr_o) && $stable(hp_rnw_o) && $stable(hp_data_o)));

  // R7
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hp_strobe_no && !hp_rnw_o) |-> hp_data_oe_o);

  // R4
  no_direct_refall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hp_strobe_no) |=> hp_strobe_no);
endmodule

bind host_port_seq host_port_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_host_port_seq.sv
`timescale 1ns/1ps
module tb_host_port_seq;
  localparam int AW = 8, DW = 16, CNT_W = 6, TO_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CNT_W-1:0] cfg_low = 4, cfg_high = 4, cfg_wait = 1;
  logic [TO_W-1:0] cfg_timeout = 200;
  logic done, err, strobe_n, rnw, oe, busy;
  logic [DW-1:0] rdata, data_o, data_i;
  logic [AW-1:0] addr_o;

  host_port_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .TO_W(TO_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_low_i(cfg_low), .cfg_high_i(cfg_high), .cfg_wait_i(cfg_wait),
    .cfg_timeout_i(cfg_timeout),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .hp_strobe_no(strobe_n), .hp_rnw_o(rnw), .hp_addr_o(addr_o),
    .hp_data_o(data_o), .hp_data_oe_o(oe), .hp_data_i(data_i), .hp_busy_i(busy)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(int i);
    return DW'(i * 16'h1357) ^ 16'hA5C3;
  endfunction
  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int max3(int a, int b, int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // slave model: busy for busy_len low cycles, inverted data while busy
  logic [DW-1:0] slave_mem [16];
  logic [DW-1:0] ref_mem [16];
  int lc = 0, busy_len = 0;
  assign busy   = !strobe_n && (lc < busy_len);
  assign data_i = busy ? ~slave_mem[addr_o[3:0]] : slave_mem[addr_o[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) slave_mem[i] <= init_val(i);
      lc <= 0;
    end else begin
      lc <= strobe_n ? 0 : lc + 1;
      if (!strobe_n && oe) slave_mem[addr_o[3:0]] <= data_o;
    end
  end

  // strobe interval monitor
  int exp_low = 0, gap_req = 1, low_len = 0, high_len = 0;
  bit prev_strobe = 1, seen_access = 0;
  logic prev_done = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!strobe_n) begin
        if (prev_strobe && seen_access)
          chk(high_len >= gap_req, "R4", "strobe high gap", high_len, gap_req);
        low_len++;
        high_len = 0;
      end else begin
        if (!prev_strobe) begin
          chk(low_len == exp_low, "R2", "strobe low length", low_len, exp_low);
          seen_access = 1;
        end
        low_len = 0;
        high_len++;
      end
      if (done && prev_done) chk(0, "R6", "done wider than one cycle", 2, 1);
      prev_strobe = strobe_n;
      prev_done   = done;
    end
  end

  task automatic do_access(bit wr, int a, logic [DW-1:0] wd, int lo, int hi, int wt,
                           int bl, int to, bit expect_to);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    gap_req   = eff(int'(cfg_high));
    cfg_low   = CNT_W'(lo);
    cfg_high  = CNT_W'(hi);
    cfg_wait  = CNT_W'(wt);
    cfg_timeout = TO_W'(to);
    busy_len  = bl;
    exp_low   = expect_to ? to + 1 : max3(eff(lo), eff(wt) + 2, bl + 3);
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = wd;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R1", "ready while busy", int'(req_ready), 0);
    guard = 0;
    while (!done && !err && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (expect_to) begin
      chk(err == 1 && done == 0, "R9", "timeout gives err without done", int'(err), 1);
      @(negedge clk);
      chk(err == 0, "R9", "err one cycle", int'(err), 0);
    end else begin
      chk(done == 1, "R6", "done seen", int'(done), 1);
      if (wr) ref_mem[a[3:0]] = wd;
      else chk(rdata == ref_mem[a[3:0]], "R5", "read data", int'(rdata), int'(ref_mem[a[3:0]]));
      if (!wr) begin
        @(negedge clk);
        chk(rdata == ref_mem[a[3:0]], "R6", "rdata held", int'(rdata), int'(ref_mem[a[3:0]]));
      end
    end
  endtask

  // R7 checked at ports while strobe low
  always @(negedge clk) begin
    if (rst_n && !finished && !strobe_n) begin
      if (rnw == 0 && (oe !== 1'b1 || data_o !== req_wdata))
        chk(0, "R7", "write data drive", int'(oe), 1);
    end
  end

  initial begin : main
    int a, wr, seed;
    logic [DW-1:0] wd;
    seed = $urandom(32'd7);
    for (int i = 0; i < 16; i++) ref_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    chk(strobe_n == 1, "R1", "reset strobe", int'(strobe_n), 1);
    chk(done == 0 && err == 0, "R1", "reset done/err", int'(done) + int'(err), 0);
    chk(req_ready == 1, "R1", "reset ready", int'(req_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed
    do_access(1, 2, 16'h1234, 4, 4, 1, 3, 200, 0);
    do_access(0, 2, '0, 4, 4, 1, 3, 200, 0);
    // R3: zero wait reads as one, low=1, no busy -> 3 low cycles
    do_access(0, 5, '0, 1, 1, 0, 0, 200, 0);
    // R2: long low minimum dominates
    do_access(0, 6, '0, 20, 2, 1, 0, 200, 0);
    // R5: long busy dominates
    do_access(0, 7, '0, 4, 4, 1, 12, 200, 0);
    // R10: burst of four words keeps order
    for (int i = 0; i < 4; i++) do_access(1, 8 + i, DW'(i + 1), 4, 4, 1, 2, 200, 0);
    for (int i = 0; i < 4; i++) do_access(0, 8 + i, '0, 4, 4, 1, 4, 200, 0);
    chk(rdata == 16'd4, "R10", "last burst word", int'(rdata), 4);
    // R9: busy never clears
    do_access(0, 3, '0, 4, 4, 1, 255, 20, 1);
    do_access(0, 3, '0, 4, 4, 1, 1, 200, 0);

    // random
    for (int n = 0; n < 60; n++) begin
      a  = $urandom_range(15, 0);
      wr = $urandom_range(1, 0);
      wd = DW'($urandom);
      do_access(wr[0], a, wd, $urandom_range(12, 0), $urandom_range(12, 0),
                $urandom_range(4, 0), $urandom_range(10, 0), 200, 0);
    end
    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule